// File: doc/BRIEF.md
# CAN Error Flag and Code Capture

This block gathers the error events reported by a CAN protocol engine and keeps them where a CPU can see them. Each kind of event (bus lock, overload frame, receive overrun, bus-off recovery, bus-off entry, error passive, error warning, bus error) latches a sticky bit in an 8-bit flag register. An 8-bit enable register selects which flags may raise the combined error interrupt, which feeds the error bit of the controller's main interrupt status register. A second 8-bit register records which kind of bus error was seen: bit error while driving dominant, bit error while driving recessive, stuff, form, CRC, ACK and ACK-delimiter errors.

The code register has a mode bit. With the mode bit at 1, codes from successive bus errors accumulate until software clears them. With the mode bit at 0, each new bus error replaces the stored code with the type or types of that error alone. Both the flag register and the code bits are cleared by writing 0 to a bit; writing 1 keeps the bit. The transmit and receive error counts computed by the protocol engine are sampled into two 8-bit registers for readout.

The register bus is a plain single-cycle write port and a combinational read port; there is no stream interface and no back-pressure, since every access completes in the cycle it is presented.

Top module: `can_err_capture`

## Requirements
- R1: After reset every register reads 0x00 and `err_irq` is 0.
- R2: A pulse on `err_evt[i]` sets flag bit i in the flag register (address 0) at the next clock edge; bit 7 bus lock, 6 overload frame, 5 receive overrun, 4 bus-off recovery, 3 bus-off entry, 2 error passive, 1 error warning, 0 bus error.
- R3: A write to the flag register clears each flag whose written bit is 0 and leaves each flag whose written bit is 1 unchanged; a write never sets a flag.
- R4: An event arriving in the same cycle as a write that clears the same flag leaves that flag set.
- R5: The enable register (address 1) is read/write, takes the written byte, and uses the flag register's bit positions.
- R6: `err_irq` is 1 exactly when some flag is both set and enabled, observed in the cycle after the register state changes.
- R7: A pulse on any bit of `bus_err_type` also sets flag bit 0 (bus error).
- R8: Code register (address 2) bit 7 is the mode bit; with it at 1, bus error types accumulate: bit 6 ACK delimiter, 5 bit error dominant, 4 bit error recessive, 3 CRC, 2 ACK, 1 form, 0 stuff, matching `bus_err_type[6:0]`.
- R9: With the mode bit at 0, a bus error event replaces code bits 6:0 with the types of that event only, even when a clearing write arrives in the same cycle.
- R10: A write to the code register clears each of bits 6:0 written 0, keeps each written 1, and loads bit 7 from the written byte; the mode in force for an event is the mode bit held before that cycle's write.
- R11: Address 3 reads the transmit error count and address 4 the receive error count, each as sampled from its input at the previous clock edge.
- R12: Reads of addresses 5 to 7 return 0x00 and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_evt | input | 8 | One-cycle error event pulses, one per flag bit |
| bus_err_type | input | 7 | One-cycle bus error type pulses |
| tx_err_cnt_i | input | 8 | Transmit error count from the protocol engine |
| rx_err_cnt_i | input | 8 | Receive error count from the protocol engine |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| err_irq | output | 1 | Combined error interrupt |

## Verification
A wrong flag or code bit shows up on `rd_data` one clock after the event or write that produced it, and a wrong flag or enable bit also shows on `err_irq` in that same cycle, so the bench compares every readable address and the interrupt after every edge. Lost event-over-clear priority or a wrong mode choice changes the code register the very next cycle and stays visible until software writes it again. The counter registers lag their inputs by exactly one edge, so a missing or extra stage is visible on the first readback.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned CODE_W  = 7;

  localparam logic [ADDR_W-1:0] A_FLAG = 3'd0;
  localparam logic [ADDR_W-1:0] A_EN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CODE = 3'd2;
  localparam logic [ADDR_W-1:0] A_TXC  = 3'd3;
  localparam logic [ADDR_W-1:0] A_RXC  = 3'd4;

  localparam int unsigned BIT_BUSERR = 0;
  localparam int unsigned BIT_MODE   = 7;
endpackage

// File: rtl/sticky_flags.sv
module sticky_flags #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_we,
  input  logic [W-1:0] keep_mask,
  output logic [W-1:0] q
);
  logic [W-1:0] keep;

  always_comb keep = clr_we ? keep_mask : {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & keep) | set_i;
  end

  // R2 / R4: an event always lands, whatever write comes with it
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((q & $past(set_i)) == $past(set_i)));

  // R3: a bit only rises because of an event
  assert_no_spurious_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & ~$past(q) & ~$past(set_i)) == '0));
endmodule

// File: rtl/err_code_reg.sv
module err_code_reg #(
  parameter int unsigned CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] type_i,
  input  logic          we,
  input  logic [CW:0]   wdata,
  output logic [CW:0]   q
);
  logic          mode_q;
  logic [CW-1:0] code_q;
  logic [CW-1:0] kept;
  logic [CW-1:0] code_d;
  logic          mode_d;
  logic          hit;

  always_comb begin
    hit    = |type_i;
    kept   = we ? (code_q & wdata[CW-1:0]) : code_q;
    mode_d = we ? wdata[CW] : mode_q;
    if (!hit)        code_d = kept;
    else if (mode_q) code_d = kept | type_i;
    else             code_d = type_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      code_q <= '0;
    end else begin
      mode_q <= mode_d;
      code_q <= code_d;
    end
  end

  assign q = {mode_q, code_q};

  assert_latest_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && hit) |=> (code_q == $past(type_i)));

  assert_accumulate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !we) |=> ((code_q & ($past(code_q) | $past(type_i)))
                         == ($past(code_q) | $past(type_i))));

  assert_mode_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mode_q == $past(wdata[CW])));
endmodule

// File: rtl/err_cnt_snap.sv
module err_cnt_snap #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tx_i,
  input  logic [W-1:0] rx_i,
  output logic [W-1:0] tx_q,
  output logic [W-1:0] rx_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_i;
      rx_q <= rx_i;
    end
  end

  assert_cnt_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tx_q == $past(tx_i) && rx_q == $past(rx_i)));
endmodule

// File: rtl/can_err_capture.sv
module can_err_capture
  import can_err_pkg::*;
#(
  parameter int unsigned RW = REG_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] err_evt,
  input  logic [CW-1:0] bus_err_type,
  input  logic [RW-1:0] tx_err_cnt_i,
  input  logic [RW-1:0] rx_err_cnt_i,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [RW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [RW-1:0] rd_data,
  output logic          err_irq
);
  logic [RW-1:0] flag_q;
  logic [RW-1:0] en_q;
  logic [CW:0]   code_q;
  logic [RW-1:0] txc_q;
  logic [RW-1:0] rxc_q;
  logic [RW-1:0] flag_set;
  logic          we_flag;
  logic          we_en;
  logic          we_code;

  always_comb begin
    we_flag  = wr_en && (wr_addr == A_FLAG);
    we_en    = wr_en && (wr_addr == A_EN);
    we_code  = wr_en && (wr_addr == A_CODE);
    flag_set = err_evt;
    flag_set[BIT_BUSERR] = err_evt[BIT_BUSERR] | (|bus_err_type);
  end

  sticky_flags #(.W(RW)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(flag_set),
    .clr_we(we_flag), .keep_mask(wr_data), .q(flag_q)
  );

  err_code_reg #(.CW(CW)) u_code (
    .clk(clk), .rst_n(rst_n), .type_i(bus_err_type),
    .we(we_code), .wdata(wr_data[CW:0]), .q(code_q)
  );

  err_cnt_snap #(.W(RW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tx_i(tx_err_cnt_i), .rx_i(rx_err_cnt_i),
    .tx_q(txc_q), .rx_q(rxc_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (we_en) en_q <= wr_data;
  end

  always_comb begin
    unique case (rd_addr)
      A_FLAG:  rd_data = flag_q;
      A_EN:    rd_data = en_q;
      A_CODE:  rd_data = RW'(code_q);
      A_TXC:   rd_data = txc_q;
      A_RXC:   rd_data = rxc_q;
      default: rd_data = '0;
    endcase
  end

  assign err_irq = |(flag_q & en_q);

  // R6: an enabled event raises the interrupt on the next cycle
  assert_irq_raise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err_evt & en_q) && !we_en) |=> err_irq);

  // R7: any bus error type lands in the bus error flag
  assert_buserr_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_err_type) |=> flag_q[BIT_BUSERR]);

  // R12: a write to an unmapped address leaves the enable register alone
  assert_unmapped_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > A_RXC) |=> $stable(en_q));
endmodule

// File: tb/can_err_capture_tb_top.sv
`timescale 1ns/1ps
module can_err_capture_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] err_evt = '0;
  logic [6:0] bus_err_type = '0;
  logic [7:0] tx_err_cnt_i = '0;
  logic [7:0] rx_err_cnt_i = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       err_irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] m_flag = '0, m_en = '0, m_code = '0, m_tx = '0, m_rx = '0;

  always #5 clk = ~clk;

  can_err_capture dut_i (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .bus_err_type(bus_err_type),
    .tx_err_cnt_i(tx_err_cnt_i), .rx_err_cnt_i(rx_err_cnt_i),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .err_irq(err_irq)
  );

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_flag;
      3'd1: return m_en;
      3'd2: return m_code;
      3'd3: return m_tx;
      3'd4: return m_rx;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1: return "R5";
      3'd2: return "R8";
      3'd3: return "R11";
      3'd4: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    rd_addr = a;
    #0.2;
    v = rd_data;
  endtask

  task automatic check_all(input string extra);
    logic [7:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk({tag_of(3'(a)), extra}, v, exp_read(3'(a)));
    end
    chk({"R6", extra}, {7'b0, err_irq}, {7'b0, |(m_flag & m_en)});
  endtask

  // Called at a negedge: drive, update model, clock once, check.
  task automatic cyc(input logic [7:0] ev, input logic [6:0] bt,
                     input logic [7:0] tx, input logic [7:0] rx,
                     input logic we, input logic [2:0] wa, input logic [7:0] wd);
    logic [6:0] kept;
    err_evt = ev; bus_err_type = bt; tx_err_cnt_i = tx; rx_err_cnt_i = rx;
    wr_en = we; wr_addr = wa; wr_data = wd;
    kept = m_code[6:0] & ((we && wa == 3'd2) ? wd[6:0] : 7'h7F);
    m_flag = (m_flag & ((we && wa == 3'd0) ? wd : 8'hFF)) | ev | {7'b0, |bt};
    if (bt != 0) kept = m_code[7] ? (kept | bt) : bt;
    m_code = {(we && wa == 3'd2) ? wd[7] : m_code[7], kept};
    if (we && wa == 3'd1) m_en = wd;
    m_tx = tx; m_rx = rx;
    @(posedge clk);
    @(negedge clk);
    err_evt = '0; bus_err_type = '0; wr_en = 1'b0;
    check_all("");
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check_all(" reset R1");

    // R2: single event on bit 4
    cyc(8'h10, 7'h00, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00);
    rd(3'd0, v); chk("R2 flag bit 4", v, 8'h10);
    // R3: write ones keeps, zero clears
    cyc(8'h00, 7'h00, 8'h00, 8'h00, 1'b1, 3'd0, 8'hFF);
    rd(3'd0, v); chk("R3 write ones keeps", v, 8'h10);
    cyc(8'h00, 7'h00, 8'h00, 8'h00, 1'b1, 3'd0, 8'hEF);
    rd(3'd0, v); chk("R3 write zero clears", v, 8'h00);
    // R4: event and clear in same cycle
    cyc(8'h80, 7'h00, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00);
    cyc(8'h80, 7'h00, 8'h00, 8'h00, 1'b1, 3'd0, 8'h00);
    rd(3'd0, v); chk("R4 event beats clear", v, 8'h80);
    // R5 / R6: enable and interrupt
    chk("R6 irq off when disabled", {7'b0, err_irq}, 8'h00);
    cyc(8'h00, 7'h00, 8'h00, 8'h00, 1'b1, 3'd1, 8'h80);
    rd(3'd1, v); chk("R5 enable readback", v, 8'h80);
    chk("R6 irq on when enabled", {7'b0, err_irq}, 8'h01);
    cyc(8'h00, 7'h00, 8'h00, 8'h00, 1'b1, 3'd0, 8'h00);
    chk("R6 irq off after clear", {7'b0, err_irq}, 8'h00);
    // R7 / R9: latest mode (mode bit 0 after reset)
    cyc(8'h00, 7'h08, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00);
    rd(3'd0, v); chk("R7 bus error flag", v, 8'h01);
    cyc(8'h00, 7'h01, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00);
    rd(3'd2, v); chk("R9 latest only", v, 8'h01);
    cyc(8'h00, 7'h24, 8'h00, 8'h00, 1'b1, 3'd2, 8'h00);
    rd(3'd2, v); chk("R9 replace under clear", v, 8'h24);
    // R10: set mode bit, clear code bits
    cyc(8'h00, 7'h00, 8'h00, 8'h00, 1'b1, 3'd2, 8'h84);
    rd(3'd2, v); chk("R10 mode load and clear", v, 8'h84);
    // R8: accumulate
    cyc(8'h00, 7'h40, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00);
    cyc(8'h00, 7'h02, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00);
    rd(3'd2, v); chk("R8 accumulate", v, 8'hC6);
    // R11: counters
    cyc(8'h00, 7'h00, 8'hA5, 8'h3C, 1'b0, 3'd0, 8'h00);
    rd(3'd3, v); chk("R11 tx count", v, 8'hA5);
    rd(3'd4, v); chk("R11 rx count", v, 8'h3C);
    // R12: unmapped write and read
    cyc(8'h00, 7'h00, 8'hA5, 8'h3C, 1'b1, 3'd6, 8'h00);
    rd(3'd6, v); chk("R12 unmapped read", v, 8'h00);
    rd(3'd1, v); chk("R12 unmapped write ignored", v, 8'h80);

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] ev;
      logic [6:0] bt;
      logic       we;
      logic [2:0] wa;
      ev = ($urandom % 6 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      bt = ($urandom % 8 == 0) ? 7'($urandom) : 7'h00;
      we = ($urandom % 4 == 0);
      wa = 3'($urandom % 6);
      cyc(ev, bt, 8'($urandom), 8'($urandom), we, wa, 8'($urandom));
    end

    done = 1;
    finish_run();
  end
endmodule